// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a countdown watchdog on a simple 32-bit register bus. Software picks a power-of-two countdown length with a 4-bit index, sets a separate index for the first countdown after enabling, and then enables the timer. From then on it must write a fixed restart code at regular intervals. If it stops doing so, the counter reaches zero and the block responds in one of two ways.

In direct mode the first expiry raises a system reset request. In two-stage mode the first expiry raises an interrupt and reloads the counter. A second expiry while that interrupt is still pending raises the reset request, so software gets one more full period to recover. The enable bit cannot be cleared by software. Only a reset of the block itself stops the timer, and the reset request stays asserted until that reset.

Top module: `wdog_twostage`

## Requirements
- R1: After block reset the control register reads 0, the count reads 0, the status reads 0, and `irq` and `sys_rst_req` are low.
- R2: Control register at offset 0x00: bit 0 enables and bit 1 selects the mode (0 direct, 1 two-stage). Once the enable bit is set, a write of 0 to it does not clear it.
- R3: While disabled, the counter at offset 0x08 holds its value and does not count.
- R4: The range register at offset 0x04 holds the period index in bits 3:0 and the initial index in bits 7:4. A write that enables the block loads 2^(BASE_LOG2+initial)-1 on that clock edge, and the count then drops by one per cycle.
- R5: A write of exactly 0x76 to offset 0x0C while enabled reloads 2^(BASE_LOG2+period)-1 and clears a pending interrupt. Any other value has no effect on the count or the interrupt.
- R6: In direct mode, the clock edge after the count has been 0 for a cycle raises `sys_rst_req`.
- R7: In two-stage mode, the first expiry raises `irq` and reloads the period value. An expiry while `irq` is already pending raises `sys_rst_req`.
- R8: A read of offset 0x14 returns the pending bit and clears it. The next expiry is then treated as a first expiry again.
- R9: `sys_rst_req` stays high until block reset. The count freezes, and restart writes have no effect.
- R10: Read-only identification words are 0xF4 = 0x00000040 (fixed periods, bit 6), 0xF8 = 0x00010300 and 0xFC = 0x57440A01. Offsets 0xE4 to 0xF0 and unmapped offsets read 0. Writes to any of these offsets are ignored.
- R11: The status register at offset 0x10 reads the pending interrupt in bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_re | input | 1 | Read strobe (a read of 0x14 clears the interrupt) |
| bus_rdata | output | 32 | Read data, valid in the cycle of `bus_re` |
| irq | output | 1 | Pending first-stage interrupt |
| sys_rst_req | output | 1 | Sticky system reset request |

## Verification
A wrong load value or decrement shows in the very next read of the count, and it moves the cycle in which `irq` or `sys_rst_req` rises. The bench pins each of those edges to a single cycle. A stage flag that is stuck or cleared too early shows up at the following expiry as an interrupt where a reset is expected, or the reverse. An enable that is not sticky shows in the next read of the control register, and the count then stops. The checks therefore sample one cycle before and one cycle after each predicted expiry.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam logic [7:0] OFS_CTRL  = 8'h00;
  localparam logic [7:0] OFS_RANGE = 8'h04;
  localparam logic [7:0] OFS_COUNT = 8'h08;
  localparam logic [7:0] OFS_KICK  = 8'h0C;
  localparam logic [7:0] OFS_STAT  = 8'h10;
  localparam logic [7:0] OFS_ICLR  = 8'h14;
  localparam logic [7:0] OFS_FEAT  = 8'hF4;
  localparam logic [7:0] OFS_VER   = 8'hF8;
  localparam logic [7:0] OFS_KIND  = 8'hFC;

  localparam logic [31:0] KICK_CODE = 32'h0000_0076;
  localparam logic [31:0] FEAT_WORD = 32'h0000_0040;
  localparam logic [31:0] VER_WORD  = 32'h0001_0300;
  localparam logic [31:0] KIND_WORD = 32'h5744_0A01;

  typedef struct packed {
    logic       en;
    logic       two_stage;
    logic [3:0] init_idx;
    logic [3:0] per_idx;
  } wdog_cfg_t;
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [31:0]       wdata,
  input  logic              re,
  input  logic [CNT_W-1:0]  count,
  input  logic              irq_pend,
  output wdog_cfg_t         cfg,
  output logic              en_set,
  output logic              kick_req,
  output logic              iclr,
  output logic [31:0]       rdata
);
  logic wr_ctrl, wr_range, wr_kick;
  logic en_q, en_d, mode_q, mode_d;
  logic [7:0] range_q, range_d;
  logic ctrl_ce, range_ce;
  logic [31:0] rmux;

  assign wr_ctrl  = we && (addr == ADDR_W'(OFS_CTRL));
  assign wr_range = we && (addr == ADDR_W'(OFS_RANGE));
  assign wr_kick  = we && (addr == ADDR_W'(OFS_KICK));

  always_comb begin
    en_d     = en_q | wdata[0];
    mode_d   = wdata[1];
    range_d  = wdata[7:0];
    ctrl_ce  = wr_ctrl;
    range_ce = wr_range;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      mode_q <= 1'b0;
    end else if (ctrl_ce) begin
      en_q   <= en_d;
      mode_q <= mode_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) range_q <= 8'h00;
    else if (range_ce) range_q <= range_d;
  end

  assign cfg.en        = en_q;
  assign cfg.two_stage = mode_q;
  assign cfg.init_idx  = range_q[7:4];
  assign cfg.per_idx   = range_q[3:0];

  assign en_set   = wr_ctrl && wdata[0] && !en_q;
  assign kick_req = wr_kick && (wdata == KICK_CODE);
  assign iclr     = re && (addr == ADDR_W'(OFS_ICLR));

  always_comb begin
    rmux = 32'h0;
    case (addr)
      ADDR_W'(OFS_CTRL):  rmux = {30'h0, mode_q, en_q};
      ADDR_W'(OFS_RANGE): rmux = {24'h0, range_q};
      ADDR_W'(OFS_COUNT): rmux = 32'(count);
      ADDR_W'(OFS_STAT):  rmux = {31'h0, irq_pend};
      ADDR_W'(OFS_ICLR):  rmux = {31'h0, irq_pend};
      ADDR_W'(OFS_FEAT):  rmux = FEAT_WORD;
      ADDR_W'(OFS_VER):   rmux = VER_WORD;
      ADDR_W'(OFS_KIND):  rmux = KIND_WORD;
      default:            rmux = 32'h0;
    endcase
    rdata = re ? rmux : 32'h0;
  end
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int CNT_W     = 32,
  parameter int BASE_LOG2 = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             load_init,
  input  logic             load_per,
  input  logic [3:0]       init_idx,
  input  logic [3:0]       per_idx,
  output logic [CNT_W-1:0] count,
  output logic             at_zero
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d, init_val, per_val;
  logic cnt_ce;

  assign init_val = (ONE << (BASE_LOG2 + int'(init_idx))) - ONE;
  assign per_val  = (ONE << (BASE_LOG2 + int'(per_idx))) - ONE;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_ce = 1'b0;
    if (load_init) begin
      cnt_d  = init_val;
      cnt_ce = 1'b1;
    end else if (load_per) begin
      cnt_d  = per_val;
      cnt_ce = 1'b1;
    end else if (run && (cnt_q != '0)) begin
      cnt_d  = cnt_q - ONE;
      cnt_ce = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (cnt_ce) cnt_q <= cnt_d;
  end

  assign count   = cnt_q;
  assign at_zero = run && (cnt_q == '0);
endmodule

// File: rtl/wdog_response.sv
module wdog_response (
  input  logic clk,
  input  logic rst_n,
  input  logic two_stage,
  input  logic expire,
  input  logic kick,
  input  logic iclr,
  output logic irq_pend,
  output logic rst_req,
  output logic reload
);
  logic irq_q, irq_d, rst_q, rst_d, irq_eff;

  always_comb begin
    irq_eff = irq_q && !iclr;
    irq_d   = irq_eff;
    rst_d   = rst_q;
    reload  = 1'b0;
    if (kick) begin
      irq_d = 1'b0;
    end else if (expire) begin
      if (two_stage && !irq_eff) begin
        irq_d  = 1'b1;
        reload = 1'b1;
      end else begin
        rst_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
      rst_q <= 1'b0;
    end else begin
      irq_q <= irq_d;
      rst_q <= rst_d;
    end
  end

  assign irq_pend = irq_q;
  assign rst_req  = rst_q;
endmodule

// File: rtl/wdog_twostage.sv
module wdog_twostage
  import wdog_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int BASE_LOG2 = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_re,
  output logic [31:0]       bus_rdata,
  output logic              irq,
  output logic              sys_rst_req
);
  localparam int CNT_W = BASE_LOG2 + 16;

  wdog_cfg_t        cfg;
  logic             en_set, kick_req, iclr;
  logic             irq_pend, rst_req, reload, at_zero;
  logic             run_w, kick_w, expire_w, en_w, mode_w;
  logic [CNT_W-1:0] cnt_w;

  wdog_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .we(bus_we), .wdata(bus_wdata),
    .re(bus_re), .count(cnt_w), .irq_pend(irq_pend), .cfg(cfg),
    .en_set(en_set), .kick_req(kick_req), .iclr(iclr), .rdata(bus_rdata)
  );

  assign en_w     = cfg.en;
  assign mode_w   = cfg.two_stage;
  assign run_w    = en_w && !rst_req;
  assign kick_w   = kick_req && run_w;
  assign expire_w = at_zero && !kick_w;

  wdog_counter #(.CNT_W(CNT_W), .BASE_LOG2(BASE_LOG2)) cnt_i (
    .clk(clk), .rst_n(rst_n), .run(run_w), .load_init(en_set),
    .load_per(kick_w || reload), .init_idx(cfg.init_idx), .per_idx(cfg.per_idx),
    .count(cnt_w), .at_zero(at_zero)
  );

  wdog_response resp_i (
    .clk(clk), .rst_n(rst_n), .two_stage(mode_w), .expire(expire_w),
    .kick(kick_w), .iclr(iclr), .irq_pend(irq_pend), .rst_req(rst_req),
    .reload(reload)
  );

  assign irq         = irq_pend;
  assign sys_rst_req = rst_req;
endmodule

// File: rtl/wdog_twostage_chk.sv
module wdog_twostage_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en_w,
  input logic             mode_w,
  input logic             kick_w,
  input logic             irq,
  input logic             sys_rst_req,
  input logic [CNT_W-1:0] cnt_w
);
  AST_EN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    en_w |=> en_w);  // R2
  AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !en_w ##1 !en_w |-> $stable(cnt_w));  // R3
  AST_KICK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    kick_w |=> (!irq && !sys_rst_req));  // R5
  AST_RST_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst_req) |-> ($past(cnt_w) == '0 && $past(en_w)));  // R6
  AST_IRQ_TWO_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(mode_w));  // R7
  AST_RST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_req |=> sys_rst_req);  // R9
  AST_FROZEN_AFTER_RST: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_req |=> $stable(cnt_w));  // R9
endmodule

bind wdog_twostage wdog_twostage_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .en_w(en_w), .mode_w(mode_w), .kick_w(kick_w),
  .irq(irq), .sys_rst_req(sys_rst_req), .cnt_w(cnt_w)
);

// File: tb/wdog_twostage_tb_top.sv
module wdog_twostage_tb_top;
  typedef struct {
    logic [31:0] exp;
    string       tag;
  } sb_item_t;

  logic        clk;
  logic        rst_n;
  logic [7:0]  bus_addr;
  logic        bus_we;
  logic [31:0] bus_wdata;
  logic        bus_re;
  logic [31:0] bus_rdata;
  logic        irq;
  logic        sys_rst_req;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  sb_item_t sb_q[$];

  wdog_twostage #(.ADDR_W(8), .BASE_LOG2(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_re(bus_re), .bus_rdata(bus_rdata),
    .irq(irq), .sys_rst_req(sys_rst_req)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Monitor: pops expected read data and compares away from the rising edge
  initial begin
    forever begin
      @(negedge clk);
      if (bus_re) begin
        checks++;
        if (sb_q.size() == 0) begin
          failures++;
          $display("FAIL scoreboard empty: read without expectation, actual=%h", bus_rdata);
        end else begin
          sb_item_t it;
          it = sb_q.pop_front();
          if (bus_rdata !== it.exp) begin
            failures++;
            $display("FAIL %s: actual=%h expected=%h", it.tag, bus_rdata, it.exp);
          end
        end
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk); #1;
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    sb_item_t it;
    it.exp = e; it.tag = tag;
    sb_q.push_back(it);
    bus_addr = a; bus_re = 1'b1;
    @(posedge clk); #1;
    bus_re = 1'b0;
  endtask

  task automatic pin(input string tag, input logic act, input logic e);
    checks++;
    if (act !== e) begin
      failures++;
      $display("FAIL %s: actual=%b expected=%b", tag, act, e);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    bus_we = 1'b0; bus_re = 1'b0; bus_addr = 8'h00; bus_wdata = 32'h0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    idle(1);
  endtask

  initial begin
    do_reset();
    // R1 reset state
    rd(8'h00, 32'h0, "R1 ctrl after reset");
    rd(8'h08, 32'h0, "R1 count after reset");
    rd(8'h10, 32'h0, "R1 status after reset");
    pin("R1 irq low", irq, 1'b0);
    pin("R1 rst_req low", sys_rst_req, 1'b0);
    // R10 identification and unmapped
    rd(8'hF4, 32'h0000_0040, "R10 feature word");
    rd(8'hF8, 32'h0001_0300, "R10 version word");
    rd(8'hFC, 32'h5744_0A01, "R10 kind word");
    rd(8'hE4, 32'h0, "R10 param E4 zero");
    rd(8'h18, 32'h0, "R10 unmapped zero");
    wr(8'hF4, 32'hFFFF_FFFF);
    rd(8'hF4, 32'h0000_0040, "R10 write to read-only ignored");

    // Session 1: direct mode, init idx 3 (32), period idx 1 (8)
    wr(8'h04, 32'h31);
    rd(8'h04, 32'h31, "R4 range readback");
    idle(3);
    rd(8'h08, 32'h0, "R3 count frozen while disabled");
    wr(8'h00, 32'h1);
    rd(8'h08, 32'd31, "R4 initial load");
    rd(8'h08, 32'd30, "R4 decrement by one");
    wr(8'h0C, 32'h75);
    rd(8'h08, 32'd28, "R5 wrong code no effect");
    wr(8'h0C, 32'h76);
    rd(8'h08, 32'd7, "R5 restart loads period");
    idle(6);
    pin("R6 no reset before expiry", sys_rst_req, 1'b0);
    rd(8'h08, 32'd0, "R6 count reached zero");
    pin("R6 reset after zero", sys_rst_req, 1'b1);
    pin("R6 no irq in direct mode", irq, 1'b0);
    idle(3);
    rd(8'h08, 32'd0, "R9 count frozen after reset request");
    pin("R9 reset request sticky", sys_rst_req, 1'b1);
    wr(8'h00, 32'h0);
    rd(8'h00, 32'h1, "R2 enable sticky");
    wr(8'h0C, 32'h76);
    pin("R9 restart ignored after reset request", sys_rst_req, 1'b1);
    rd(8'h08, 32'd0, "R9 restart does not reload");

    // Session 2: two-stage, init idx 1 (8), period idx 0 (4)
    do_reset();
    wr(8'h04, 32'h10);
    wr(8'h00, 32'h3);
    rd(8'h00, 32'h3, "R2 mode and enable read");
    idle(6);
    pin("R7 no irq before expiry", irq, 1'b0);
    idle(1);
    pin("R7 first expiry raises irq", irq, 1'b1);
    pin("R7 first expiry no reset", sys_rst_req, 1'b0);
    rd(8'h10, 32'h1, "R11 status shows pending");
    rd(8'h08, 32'd2, "R7 reload after first expiry");
    rd(8'h14, 32'h1, "R8 clear read returns pending");
    pin("R8 irq cleared", irq, 1'b0);
    idle(1);
    pin("R8 next expiry is first again", irq, 1'b1);
    pin("R8 no reset after cleared stage", sys_rst_req, 1'b0);
    idle(3);
    pin("R7 no reset before second expiry", sys_rst_req, 1'b0);
    idle(1);
    pin("R7 second expiry raises reset", sys_rst_req, 1'b1);

    // Session 3: two-stage, both indices 2 (16); restart clears stage
    do_reset();
    wr(8'h04, 32'h22);
    wr(8'h00, 32'h3);
    idle(16);
    pin("R7 irq after 16 cycles", irq, 1'b1);
    wr(8'h0C, 32'h76);
    pin("R5 restart clears irq", irq, 1'b0);
    rd(8'h08, 32'd15, "R5 restart reload value");
    idle(14);
    pin("R5 no irq before next expiry", irq, 1'b0);
    idle(1);
    pin("R5 expiry after restart is first stage", irq, 1'b1);
    pin("R5 no reset after restart", sys_rst_req, 1'b0);
    wr(8'h0C, 32'h77);
    pin("R5 wrong code keeps irq", irq, 1'b1);
    rd(8'h08, 32'd14, "R5 wrong code keeps count");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule